// File: doc/BRIEF.md
# SD Host Global Register Block

This block is the shared register front end placed ahead of one or two standard SD host slot controllers. It decodes single-word 32-bit reads and writes inside a 4 KB window. It keeps a small set of global registers of its own: a control/info word, a debounce setting, a bus setting, a write-protect polarity word and a card-detect word. It also shows an interrupt status word that follows the per-slot interrupt lines.

Accesses to a slot's own register window, and to the fixed alias addresses of each slot's capability and maximum-current registers, are passed to a shared slot access port. The port carries a slot select and a byte offset inside that slot's window. A read is answered one cycle after its request. The slot interrupt lines are registered into the status word, and their OR drives a single interrupt output. Writing a 1 to bit 0 of the info word sends a one-cycle reset pulse to the slot controllers. That bit is never stored.

Top module: `sdw_glue_regs`

## Requirements
- R1: After reset the info word (0x00) reads 0x00010000 with bit 17 also set when NUM_SLOTS is 2 (0x00030000 by default), the debounce word (0x04) reads 0x00000005, the words at 0x08, 0xEC, 0xF0 and 0xFC read 0, and `irq` and `slot_rst_pulse` are 0.
- R2: A write to 0x00 stores every bit except bit 0, and bit 0 always reads back as 0.
- R3: A write to 0x00 with bit 0 set drives `slot_rst_pulse` high for exactly the one cycle that follows the write. A write with bit 0 clear produces no pulse.
- R4: The words at 0x04, 0x08, 0xEC and 0xF0 are full 32-bit read/write storage.
- R5: Alias addresses 0x10 and 0x18 reach slot 0 at offsets 0x40 (capability) and 0x48 (maximum current), and 0x20 and 0x28 reach slot 1 at the same offsets. They assert `sl_req` with that slot on `sl_sel`, return `sl_rdata` of that slot, and leave the local words unchanged.
- R6: Byte addresses 0x100–0x1FF reach slot 0 and 0x200–0x2FF reach slot 1 (the latter only when NUM_SLOTS is 2), with `sl_addr` equal to the low 8 address bits.
- R7: Bit n of the status word at 0xFC equals `slot_irq[n]` as sampled at the previous clock edge. Writes to 0xFC have no effect.
- R8: `irq` is 1 in the cycle after any `slot_irq` bit is 1 and 0 in the cycle after all are 0, so a slot dropping its line does not hide another slot's pending line.
- R9: Reads at unaligned addresses, at unassigned local offsets, or at 0x300 and above return 0. Writes there change nothing and raise no `sl_req`.
- R10: Every request gives `rsp_valid` in the next cycle. `rsp_rdata` carries the read data for reads and 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| slot_irq | input | NUM_SLOTS | Interrupt level from each slot controller |
| irq | output | 1 | Merged interrupt |
| slot_rst_pulse | output | 1 | One-cycle reset request to the slot controllers |
| sl_req | output | 1 | Slot access strobe (same cycle as the request) |
| sl_write | output | 1 | Slot access direction |
| sl_sel | output | 1 | Selected slot |
| sl_addr | output | 8 | Byte offset inside the selected slot window |
| sl_wdata | output | 32 | Slot write data |
| sl_rdata | input | 32*NUM_SLOTS | Read data of each slot, slot n at bits [32n+31:32n] |

## Verification
The hardest case to reach from the ports is two slots with overlapping interrupts, where one slot drops its line while the other still holds its line. The stimulus raises slot 0, then both, then leaves only slot 1, and after each step it reads the status word and samples `irq`. A second hard case is proving that an alias and the slot window reach the same slot register. To do this, the bench writes through the alias at 0x18 and reads the value back at 0x148 in the window of slot 0. A bench model of the slot registers answers both paths.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // Local word offsets (low byte of the address)
    localparam logic [7:0] LOC_INFO     = 8'h00;
    localparam logic [7:0] LOC_DEBOUNCE = 8'h04;
    localparam logic [7:0] LOC_BUS      = 8'h08;
    localparam logic [7:0] LOC_WPPOL    = 8'hEC;
    localparam logic [7:0] LOC_CDET     = 8'hF0;
    localparam logic [7:0] LOC_ISTAT    = 8'hFC;

    // Fixed aliases onto slot capability / max-current words
    localparam logic [ADDR_W-1:0] ALI_CAP0  = 12'h010;
    localparam logic [ADDR_W-1:0] ALI_MCUR0 = 12'h018;
    localparam logic [ADDR_W-1:0] ALI_CAP1  = 12'h020;
    localparam logic [ADDR_W-1:0] ALI_MCUR1 = 12'h028;

    localparam logic [7:0] SLOT_CAP_OFS  = 8'h40;
    localparam logic [7:0] SLOT_MCUR_OFS = 8'h48;

    localparam int INFO_RST_BIT   = 0;
    localparam int INFO_SLOT0_BIT = 16;
    localparam logic [DATA_W-1:0] DEBOUNCE_INIT = 32'h0000_0005;

    typedef enum logic [1:0] {
        RG_LOCAL,
        RG_ALIAS,
        RG_WINDOW,
        RG_NONE
    } region_e;

    typedef struct packed {
        region_e    region;
        logic       slot;
        logic [7:0] sub_addr;
    } route_t;

    typedef struct packed {
        logic [DATA_W-1:0] info;
        logic [DATA_W-1:0] debounce;
        logic [DATA_W-1:0] bus;
        logic [DATA_W-1:0] wppol;
        logic [DATA_W-1:0] cdet;
    } glue_regs_t;

    function automatic route_t route_addr(input logic [ADDR_W-1:0] a, input int nslots);
        route_t r;
        r.region   = RG_NONE;
        r.slot     = 1'b0;
        r.sub_addr = a[7:0];
        if (a[1:0] == 2'b00) begin
            if (a[11:8] == 4'h0) begin
                if (a == ALI_CAP0 || a == ALI_MCUR0 || a == ALI_CAP1 || a == ALI_MCUR1) begin
                    r.slot     = a[5];
                    r.sub_addr = a[3] ? SLOT_MCUR_OFS : SLOT_CAP_OFS;
                    r.region   = (int'(a[5]) < nslots) ? RG_ALIAS : RG_NONE;
                end else begin
                    r.region = RG_LOCAL;
                end
            end else if (int'(a[11:8]) <= nslots) begin
                r.region = RG_WINDOW;
                r.slot   = a[9];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output route_t            route
);
    always_comb begin
        route = route_addr(addr, NUM_SLOTS);
    end
endmodule

// File: rtl/sdw_irq_merge.sv
module sdw_irq_merge #(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] slot_irq,
    output logic [NUM_SLOTS-1:0] status,
    output logic                 irq
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= slot_irq;
    end

    assign irq = |status;
endmodule

// File: rtl/sdw_local_regs.sv
module sdw_local_regs
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SLOTS-1:0] istat,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rst_pulse
);
    localparam logic [DATA_W-1:0] SLOT0_MASK = DATA_W'(1) << INFO_SLOT0_BIT;
    localparam logic [DATA_W-1:0] SLOT1_MASK = (NUM_SLOTS == 2) ? (DATA_W'(1) << (INFO_SLOT0_BIT + 1)) : '0;
    localparam logic [DATA_W-1:0] INFO_INIT  = SLOT0_MASK | SLOT1_MASK;
    localparam logic [DATA_W-1:0] KEEP_MASK  = ~(DATA_W'(1) << INFO_RST_BIT);

    glue_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.info     <= INFO_INIT;
            regs_q.debounce <= DEBOUNCE_INIT;
            regs_q.bus      <= '0;
            regs_q.wppol    <= '0;
            regs_q.cdet     <= '0;
            rst_pulse       <= 1'b0;
        end else begin
            rst_pulse <= wr_en && (addr == LOC_INFO) && wdata[INFO_RST_BIT];
            if (wr_en) begin
                case (addr)
                    LOC_INFO:     regs_q.info     <= wdata & KEEP_MASK;
                    LOC_DEBOUNCE: regs_q.debounce <= wdata;
                    LOC_BUS:      regs_q.bus      <= wdata;
                    LOC_WPPOL:    regs_q.wppol    <= wdata;
                    LOC_CDET:     regs_q.cdet     <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            LOC_INFO:     rdata = regs_q.info;
            LOC_DEBOUNCE: rdata = regs_q.debounce;
            LOC_BUS:      rdata = regs_q.bus;
            LOC_WPPOL:    rdata = regs_q.wppol;
            LOC_CDET:     rdata = regs_q.cdet;
            LOC_ISTAT:    rdata = DATA_W'(istat);
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdw_glue_regs.sv
module sdw_glue_regs
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata,
    input  logic [NUM_SLOTS-1:0]        slot_irq,
    output logic                        irq,
    output logic                        slot_rst_pulse,
    output logic                        sl_req,
    output logic                        sl_write,
    output logic                        sl_sel,
    output logic [7:0]                  sl_addr,
    output logic [DATA_W-1:0]           sl_wdata,
    input  logic [NUM_SLOTS*DATA_W-1:0] sl_rdata
);
    route_t                route;
    logic                  to_slot;
    logic                  loc_wr;
    logic [DATA_W-1:0]     loc_rdata;
    logic [DATA_W-1:0]     slot_word;
    logic [DATA_W-1:0]     rd_word;
    logic [NUM_SLOTS-1:0]  istat;

    sdw_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr  (req_addr),
        .route (route)
    );

    assign to_slot  = (route.region == RG_ALIAS) || (route.region == RG_WINDOW);
    assign loc_wr   = req_valid && req_write && (route.region == RG_LOCAL);

    assign sl_req   = req_valid && to_slot;
    assign sl_write = req_write;
    assign sl_sel   = route.slot;
    assign sl_addr  = route.sub_addr;
    assign sl_wdata = req_wdata;

    sdw_irq_merge #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .slot_irq (slot_irq),
        .status   (istat),
        .irq      (irq)
    );

    sdw_local_regs #(.NUM_SLOTS(NUM_SLOTS)) u_loc (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (loc_wr),
        .addr      (req_addr[7:0]),
        .wdata     (req_wdata),
        .istat     (istat),
        .rdata     (loc_rdata),
        .rst_pulse (slot_rst_pulse)
    );

    generate
        if (NUM_SLOTS == 1) begin : g_one
            assign slot_word = sl_rdata[DATA_W-1:0];
        end else begin : g_two
            assign slot_word = route.slot ? sl_rdata[2*DATA_W-1:DATA_W] : sl_rdata[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        case (route.region)
            RG_LOCAL:  rd_word = loc_rdata;
            RG_ALIAS,
            RG_WINDOW: rd_word = slot_word;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/sdw_glue_chk.sv
module sdw_glue_chk #(
    parameter int NUM_SLOTS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [11:0]          req_addr,
    input logic [31:0]          req_wdata,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic [NUM_SLOTS-1:0] slot_irq,
    input logic                 irq,
    input logic                 slot_rst_pulse,
    input logic                 sl_req
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    write_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));

    // R2
    info_bit0_low_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 12'h000) |=> (rsp_rdata[0] == 1'b0));

    // R3
    rst_pulse_make_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 12'h000 && req_wdata[0]) |=> slot_rst_pulse);

    // R3
    rst_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        slot_rst_pulse |-> $past(req_valid && req_write && req_addr == 12'h000 && req_wdata[0]));

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (|slot_irq) |=> irq);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(|slot_irq) |=> !irq);

    // R9
    far_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[11:10] != 2'b00) |=> (rsp_rdata == 32'h0));

    // R9
    far_no_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[11:10] != 2'b00) |-> !sl_req);
endmodule

bind sdw_glue_regs sdw_glue_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/sim_sdw_glue_regs.sv
`timescale 1ns/1ps
module sim_sdw_glue_regs;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NS-1:0] slot_irq = '0;
    logic          irq;
    logic          slot_rst_pulse;
    logic          sl_req;
    logic          sl_write;
    logic          sl_sel;
    logic [7:0]    sl_addr;
    logic [31:0]   sl_wdata;
    logic [NS*32-1:0] sl_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] smem [NS][64];

    always #4 clk = ~clk;

    sdw_glue_regs #(.NUM_SLOTS(NS)) u0 (.*);

    // Slot controller model: per-slot 64-word register windows
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++)
                for (int i = 0; i < 64; i++)
                    smem[s][i] <= 32'h5100_0000 | (s << 16) | i;
        end else if (sl_req && sl_write) begin
            smem[sl_sel][sl_addr[7:2]] <= sl_wdata;
        end
    end
    assign sl_rdata = {smem[1][sl_addr[7:2]], smem[0][sl_addr[7:2]]};

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected response words
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    // Driver: one request, expected response pushed to the scoreboard
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_q.push_back(wr ? 32'h0 : exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Same as access, but also checks the slot port during the request
    task automatic probe(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         input logic [31:0] exp, input logic ereq, input logic esel,
                         input logic [7:0] eaddr, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        exp_q.push_back(wr ? 32'h0 : exp);
        tag_q.push_back(tag);
        #1;
        chk(sl_req === ereq, {tag, " sl_req"}, 32'(sl_req), 32'(ereq));
        if (ereq) begin
            chk(sl_sel === esel, {tag, " sl_sel"}, 32'(sl_sel), 32'(esel));
            chk(sl_addr === eaddr, {tag, " sl_addr"}, 32'(sl_addr), 32'(eaddr));
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(irq === 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
        chk(slot_rst_pulse === 1'b0, "R1 pulse after reset", 32'(slot_rst_pulse), 32'h0);
        access(0, 12'h000, 0, 32'h0003_0000, "R1 info reset");
        access(0, 12'h004, 0, 32'h0000_0005, "R1 debounce reset");
        access(0, 12'h008, 0, 32'h0, "R1 bus reset");
        access(0, 12'h0EC, 0, 32'h0, "R1 wppol reset");
        access(0, 12'h0F0, 0, 32'h0, "R1 cdet reset");
        access(0, 12'h0FC, 0, 32'h0, "R1 istat reset");

        // R2 / R3 info register and reset pulse
        access(1, 12'h000, 32'hDEAD_BEEF, 0, "R10 write response");
        chk(slot_rst_pulse === 1'b1, "R3 pulse high", 32'(slot_rst_pulse), 32'h1);
        @(negedge clk);
        chk(slot_rst_pulse === 1'b0, "R3 pulse one cycle", 32'(slot_rst_pulse), 32'h0);
        access(0, 12'h000, 0, 32'hDEAD_BEEE, "R2 info bit0 clear");
        access(1, 12'h000, 32'h1234_5678, 0, "R10 write response");
        chk(slot_rst_pulse === 1'b0, "R3 no pulse when bit0 low", 32'(slot_rst_pulse), 32'h0);
        access(0, 12'h000, 0, 32'h1234_5678, "R2 info stored");

        // R4 storage words
        access(1, 12'h004, 32'hA5A5_0F0F, 0, "R10 write response");
        access(1, 12'h008, 32'h0000_00C3, 0, "R10 write response");
        access(1, 12'h0EC, 32'hFFFF_FFFF, 0, "R10 write response");
        access(1, 12'h0F0, 32'h8000_0001, 0, "R10 write response");
        access(0, 12'h004, 0, 32'hA5A5_0F0F, "R4 debounce");
        access(0, 12'h008, 0, 32'h0000_00C3, "R4 bus");
        access(0, 12'h0EC, 0, 32'hFFFF_FFFF, "R4 wppol");
        access(0, 12'h0F0, 0, 32'h8000_0001, "R4 cdet");

        // R5 aliases
        probe(0, 12'h010, 0, 32'h5100_0010, 1, 0, 8'h40, "R5 cap slot0");
        probe(0, 12'h028, 0, 32'h5101_0012, 1, 1, 8'h48, "R5 mcur slot1");
        probe(1, 12'h018, 32'hCAFE_0001, 0, 1, 0, 8'h48, "R5 mcur slot0 write");
        probe(0, 12'h148, 0, 32'hCAFE_0001, 1, 0, 8'h48, "R5 alias reaches slot0 window");
        probe(1, 12'h020, 32'h0BAD_F00D, 0, 1, 1, 8'h40, "R5 cap slot1 write");
        access(0, 12'h020, 0, 32'h0BAD_F00D, "R5 cap slot1 readback");
        access(0, 12'h008, 0, 32'h0000_00C3, "R5 local untouched");

        // R6 slot windows
        probe(0, 12'h204, 0, 32'h5101_0001, 1, 1, 8'h04, "R6 slot1 read");
        probe(1, 12'h2FC, 32'h0000_0077, 0, 1, 1, 8'hFC, "R6 slot1 write");
        access(0, 12'h2FC, 0, 32'h0000_0077, "R6 slot1 readback");
        probe(0, 12'h100, 0, 32'h5100_0000, 1, 0, 8'h00, "R6 slot0 read");

        // R7 / R8 interrupts
        @(negedge clk); slot_irq = 2'b01;
        @(negedge clk);
        chk(irq === 1'b1, "R8 irq from slot0", 32'(irq), 32'h1);
        access(0, 12'h0FC, 0, 32'h1, "R7 istat slot0");
        slot_irq = 2'b11;
        access(0, 12'h0FC, 0, 32'h3, "R7 istat both");
        slot_irq = 2'b10;
        @(negedge clk);
        chk(irq === 1'b1, "R8 irq held by slot1", 32'(irq), 32'h1);
        access(0, 12'h0FC, 0, 32'h2, "R7 istat slot1 only");
        slot_irq = 2'b00;
        @(negedge clk);
        chk(irq === 1'b0, "R8 irq clear", 32'(irq), 32'h0);
        access(1, 12'h0FC, 32'hFFFF_FFFF, 0, "R10 write response");
        access(0, 12'h0FC, 0, 32'h0, "R7 istat read-only");

        // R9 unmapped space
        probe(0, 12'h300, 0, 32'h0, 0, 0, 8'h00, "R9 read beyond windows");
        probe(1, 12'h3F0, 32'h1111_2222, 0, 0, 0, 8'h00, "R9 write beyond windows");
        access(1, 12'h0A0, 32'h5555_5555, 0, "R10 write response");
        access(0, 12'h0A0, 0, 32'h0, "R9 unassigned local");
        access(0, 12'h005, 0, 32'h0, "R9 unaligned read");
        probe(1, 12'h006, 32'h9999_9999, 0, 0, 0, 8'h00, "R9 unaligned write");
        access(0, 12'h004, 0, 32'hA5A5_0F0F, "R9 debounce unchanged");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all responses seen", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule